// File: doc/BRIEF.md
# Second-Pulse Armed Timebase with Scheduled Operations

This block keeps the sample-clock time of a receiver. A 64-bit counter runs freely and advances by one on each sample clock, so the time resolution is one clock period (about 8.33 ns at a 120 MHz sample clock). The current count is exported so that packet framers can stamp outgoing sample frames with it.

Software can realign the counter. It first writes a pending time value over a register-style write port and then arms the block. The pending value is loaded on the next rising edge of the asynchronous pulse-per-second input, after that edge has been synchronised. The value can be anything software picks, for example an absolute satellite-derived time or zero. Without arming, second pulses are ignored.

The same port fills a short first-in first-out queue of scheduled operations: tune, stream start and gain change. Each operation carries a due time and a 32-bit argument. Only the oldest entry is compared with the counter. When its due time is reached, the block pulses a strobe for one cycle, presents the operation's kind and argument, and pops the entry. Entries that are already overdue fire at once and set a sticky lateness flag. A push into a full queue is dropped and sets a sticky overflow flag.

Top module: `pps_timebase`

## Requirements
- R1: Outside a load, `time_now` rises by exactly one on every clock cycle. Reset sets `time_now` to zero.
- R2: Writing address 0 sets the low 32 bits of the pending time and address 1 sets the high 32 bits. Writing address 2 with bit 0 = 1 arms the block, and bit 0 = 0 disarms it. Once `pps_in` goes high and is armed, `time_set` pulses high in the third cycle after the input change. In the following cycle `time_now` equals the pending time, and it counts up from there.
- R3: `armed` clears by itself in the cycle in which the pending time appears on `time_now`. `time_set` is high for a single cycle.
- R4: A rising `pps_in` while the block is not armed leaves `time_now` counting normally and produces no `time_set`.
- R5: A load needs a new low-to-high transition of `pps_in`. Arming while `pps_in` is already held high does not load until `pps_in` falls and rises again.
- R6: An operation is staged as follows: the due time low half goes to address 3, the high half to address 4 and the argument to address 5. A write to address 6 pushes it, with the kind taken from data bits 1:0 (0 = tune, 1 = stream start, 2 = gain change, 3 = spare). `fire_valid` is high for one cycle with `time_now` equal to the due time, and `fire_kind` and `fire_arg` carry the operation.
- R7: Operations fire strictly in push order. Only the oldest entry is compared, so a later entry with an earlier due time waits and fires in the cycle after the entry ahead of it.
- R8: An entry whose due time is already passed when it is compared fires as early as it can, with `fire_late` high. This also sets the sticky `late_flag`. An on-time firing leaves `late_flag` unchanged. Writing address 7 with bit 0 = 1 clears `late_flag`.
- R9: The queue holds 4 entries. A push while it is full is discarded, never fires, and sets the sticky `ovf_flag`. Writing address 7 with bit 1 = 1 clears `ovf_flag`.
- R10: While reset is held, `armed`, `time_set`, `fire_valid`, `late_flag` and `ovf_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous second pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| time_now | output | 64 | Current time count |
| armed | output | 1 | Pending time waits for a second pulse |
| time_set | output | 1 | One-cycle pulse, load happens next cycle |
| fire_valid | output | 1 | One-cycle operation strobe |
| fire_kind | output | 2 | Kind of the firing operation |
| fire_arg | output | 32 | Argument of the firing operation |
| fire_late | output | 1 | Firing operation was overdue |
| late_flag | output | 1 | Sticky overdue indicator |
| ovf_flag | output | 1 | Sticky dropped-push indicator |

## Verification
Some properties are checked by assertions on every cycle. These are the unit step of the counter, the loaded value landing one cycle after the internal load request, and arming as a precondition for any load. They also cover the automatic disarm, the single-cycle edge pulse, the bound on queue occupancy, overflow on a full push, and an overdue firing raising the sticky flag. Other behaviour only the bench scenarios can show. A scoreboard model predicts, for each pushed operation, the exact cycle it fires, its kind, argument and lateness. The bench measures the pulse-to-load latency and checks that a held-high pulse is ignored. It confirms that a dropped push never appears at the output, and that flags clear only on request.

// File: rtl/ppstb_pkg.sv
package ppstb_pkg;

    localparam int TIME_W    = 64;
    localparam int ARG_W     = 32;
    localparam int HALF_W    = TIME_W / 2;
    localparam int REG_A_W   = 3;
    localparam int KIND_W    = 2;

    typedef logic [TIME_W-1:0] stamp_t;

    typedef enum logic [KIND_W-1:0] {
        OP_TUNE   = 2'd0,
        OP_STREAM = 2'd1,
        OP_GAIN   = 2'd2,
        OP_SPARE  = 2'd3
    } op_kind_e;

    typedef struct packed {
        stamp_t              due;
        op_kind_e            kind;
        logic [ARG_W-1:0]    arg;
    } timed_op_t;

    typedef enum logic [REG_A_W-1:0] {
        RA_PEND_LO = 3'd0,
        RA_PEND_HI = 3'd1,
        RA_ARM     = 3'd2,
        RA_OP_LO   = 3'd3,
        RA_OP_HI   = 3'd4,
        RA_OP_ARG  = 3'd5,
        RA_OP_PUSH = 3'd6,
        RA_CLEAR   = 3'd7
    } reg_addr_e;

    function automatic stamp_t join_halves(input logic [HALF_W-1:0] hi,
                                           input logic [HALF_W-1:0] lo);
        return {hi, lo};
    endfunction

    // Overdue when the comparison time has already moved beyond the due time.
    function automatic logic is_overdue(input stamp_t ref_t, input stamp_t due);
        return ref_t > due;
    endfunction

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_async,
    output logic pulse_rise
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], pulse_async};
    end

    // Last synchroniser stage high, delayed copy still low.
    assign pulse_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_rise |=> !pulse_rise);

endmodule

// File: rtl/host_regs.sv
module host_regs
    import ppstb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_A_W-1:0]  wr_addr,
    input  logic [ARG_W-1:0]    wr_data,
    input  logic                load_done,
    output stamp_t              pending,
    output logic                armed,
    output logic                push_req,
    output timed_op_t           push_op,
    output logic                clr_late,
    output logic                clr_ovf
);
    logic [HALF_W-1:0] pend_lo, pend_hi, op_lo, op_hi;
    logic [ARG_W-1:0]  op_arg;
    reg_addr_e         sel;

    assign sel = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_lo <= '0;
            pend_hi <= '0;
            op_lo   <= '0;
            op_hi   <= '0;
            op_arg  <= '0;
            armed   <= 1'b0;
        end else begin
            if (load_done) armed <= 1'b0;
            if (wr_en) begin
                case (sel)
                    RA_PEND_LO: pend_lo <= wr_data[HALF_W-1:0];
                    RA_PEND_HI: pend_hi <= wr_data[HALF_W-1:0];
                    RA_ARM:     armed   <= wr_data[0];
                    RA_OP_LO:   op_lo   <= wr_data[HALF_W-1:0];
                    RA_OP_HI:   op_hi   <= wr_data[HALF_W-1:0];
                    RA_OP_ARG:  op_arg  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign pending  = join_halves(pend_hi, pend_lo);
    assign push_req = wr_en && (sel == RA_OP_PUSH);
    assign clr_late = wr_en && (sel == RA_CLEAR) && wr_data[0];
    assign clr_ovf  = wr_en && (sel == RA_CLEAR) && wr_data[1];

    always_comb begin
        push_op      = '0;
        push_op.due  = join_halves(op_hi, op_lo);
        push_op.kind = op_kind_e'(wr_data[KIND_W-1:0]);
        push_op.arg  = op_arg;
    end

endmodule

// File: rtl/time_counter.sv
module time_counter
    import ppstb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pps_rise,
    input  logic   armed,
    input  stamp_t pending,
    output stamp_t now,
    output stamp_t next_now,
    output logic   load_req
);
    always_comb begin
        if (load_req) next_now = pending;
        else          next_now = now + stamp_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now      <= '0;
            load_req <= 1'b0;
        end else begin
            now      <= next_now;
            load_req <= pps_rise & armed;
        end
    end

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        !load_req |=> now == $past(now) + stamp_t'(1));

    p_load_value_r2: assert property (@(posedge clk) disable iff (rst)
        load_req |=> now == $past(pending));

endmodule

// File: rtl/op_queue.sv
module op_queue
    import ppstb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  timed_op_t push_op,
    input  logic      pop,
    output timed_op_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    timed_op_t         slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              take, give;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign take  = push && !full;
    assign give  = pop && !empty;
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (take) slots[wr_ptr] <= push_op;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (take) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (give) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({take, give})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: ;
            endcase
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/pps_timebase.sv
module pps_timebase
    import ppstb_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pps_in,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [31:0]        wr_data,
    output logic [63:0]        time_now,
    output logic               armed,
    output logic               time_set,
    output logic               fire_valid,
    output logic [1:0]         fire_kind,
    output logic [31:0]        fire_arg,
    output logic               fire_late,
    output logic               late_flag,
    output logic               ovf_flag
);
    logic      pps_rise, load_req, push_req, clr_late, clr_ovf;
    logic      q_empty, q_full, fire_now, overdue;
    stamp_t    pending, now, next_now;
    timed_op_t push_op, head;

    pps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .pulse_async (pps_in),
        .pulse_rise  (pps_rise)
    );

    host_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_done (load_req),
        .pending   (pending),
        .armed     (armed),
        .push_req  (push_req),
        .push_op   (push_op),
        .clr_late  (clr_late),
        .clr_ovf   (clr_ovf)
    );

    time_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .pps_rise (pps_rise),
        .armed    (armed),
        .pending  (pending),
        .now      (now),
        .next_now (next_now),
        .load_req (load_req)
    );

    op_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push    (push_req),
        .push_op (push_op),
        .pop     (fire_now),
        .head    (head),
        .empty   (q_empty),
        .full    (q_full)
    );

    // Compare against the value the counter takes at this edge, so the
    // strobe lines up with time_now equal to the due time.
    assign fire_now = !q_empty && (next_now >= head.due);
    assign overdue  = is_overdue(next_now, head.due);

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_valid <= 1'b0;
            fire_kind  <= '0;
            fire_arg   <= '0;
            fire_late  <= 1'b0;
            late_flag  <= 1'b0;
            ovf_flag   <= 1'b0;
        end else begin
            fire_valid <= fire_now;
            if (fire_now) begin
                fire_kind <= head.kind;
                fire_arg  <= head.arg;
                fire_late <= overdue;
            end else begin
                fire_late <= 1'b0;
            end
            if (fire_now && overdue) late_flag <= 1'b1;
            else if (clr_late)       late_flag <= 1'b0;
            if (push_req && q_full)  ovf_flag  <= 1'b1;
            else if (clr_ovf)        ovf_flag  <= 1'b0;
        end
    end

    assign time_now = now;
    assign time_set = load_req;

    p_set_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
        time_set |-> $past(armed));

    p_auto_disarm_r3: assert property (@(posedge clk) disable iff (rst)
        (time_set && !wr_en) |=> !armed);

    p_set_single_r3: assert property (@(posedge clk) disable iff (rst)
        time_set |=> !time_set);

    p_ovf_on_full_r9: assert property (@(posedge clk) disable iff (rst)
        (push_req && q_full) |=> ovf_flag);

    p_late_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (fire_valid && fire_late) |-> late_flag);

    p_fire_on_due_r6: assert property (@(posedge clk) disable iff (rst)
        (fire_valid && !fire_late) |-> $past(fire_now));

endmodule

// File: tb/pps_timebase_tb.sv
module pps_timebase_tb;

    typedef struct {
        logic [63:0] due;
        logic [1:0]  kind;
        logic [31:0] arg;
        bit          late;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [63:0] time_now;
    logic        armed, time_set, fire_valid, fire_late, late_flag, ovf_flag;
    logic [1:0]  fire_kind;
    logic [31:0] fire_arg;

    int          errors = 0;
    int          checks = 0;
    int          set_pulses = 0;
    logic [63:0] last_exp = '0;
    exp_t        exp_q[$];

    always #2.5 clk = ~clk;

    pps_timebase u_dut (
        .clk(clk), .rst(rst), .pps_in(pps_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .time_now(time_now), .armed(armed), .time_set(time_set),
        .fire_valid(fire_valid), .fire_kind(fire_kind), .fire_arg(fire_arg),
        .fire_late(fire_late), .late_flag(late_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: stages an operation, predicts its firing and pushes it.
    task automatic push_op(input logic [63:0] t, input logic [1:0] k,
                           input logic [31:0] a);
        exp_t        e;
        logic [63:0] c;
        wr(3'd3, t[31:0]);
        wr(3'd4, t[63:32]);
        wr(3'd5, a);
        @(negedge clk);
        c = time_now;
        e.due = t;
        if (c + 64'd2 > e.due)       e.due = c + 64'd2;
        if (last_exp + 64'd1 > e.due) e.due = last_exp + 64'd1;
        e.late = (e.due != t);
        e.kind = k;
        e.arg  = a;
        last_exp = e.due;
        exp_q.push_back(e);
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = {30'd0, k};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R6 queue drained", 64'(exp_q.size()), 64'd0);
    endtask

    // Monitor: compares every strobe with the oldest prediction.
    always @(negedge clk) begin
        if (!rst && time_set) set_pulses++;
        if (!rst && fire_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected firing", 64'(fire_arg), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(time_now == e.due, "R6/R7 firing time", time_now, e.due);
                chk(fire_kind == e.kind, "R6 kind", 64'(fire_kind), 64'(e.kind));
                chk(fire_arg == e.arg, "R6 argument", 64'(fire_arg), 64'(e.arg));
                chk(fire_late == e.late, "R8 fire_late", 64'(fire_late), 64'(e.late));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] t;
        logic [63:0] pend;
        int          sp;
        pend = 64'h1234_5678_9ABC_DEF0;

        // R10 reset state
        repeat (4) @(negedge clk);
        chk(time_now == 64'd0, "R10 time in reset", time_now, 64'd0);
        chk({armed, time_set, fire_valid, late_flag, ovf_flag} == 5'd0,
            "R10 outputs in reset",
            64'({armed, time_set, fire_valid, late_flag, ovf_flag}), 64'd0);
        rst = 1'b0;

        // R1 free running count
        @(negedge clk);
        t = time_now;
        repeat (10) @(negedge clk);
        chk(time_now == t + 64'd10, "R1 count step", time_now, t + 64'd10);

        // R2 / R3 armed load
        wr(3'd0, pend[31:0]);
        wr(3'd1, pend[63:32]);
        wr(3'd2, 32'd1);
        chk(armed == 1'b1, "R2 armed after write", 64'(armed), 64'd1);
        pps_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(time_set == 1'b1, "R2 time_set latency", 64'(time_set), 64'd1);
        @(negedge clk);
        chk(time_now == pend, "R2 loaded value", time_now, pend);
        chk(armed == 1'b0, "R3 auto disarm", 64'(armed), 64'd0);
        chk(time_set == 1'b0, "R3 single pulse", 64'(time_set), 64'd0);
        @(negedge clk);
        chk(time_now == pend + 64'd1, "R1 count after load", time_now, pend + 64'd1);

        // R4 unarmed pulse ignored
        pps_in = 1'b0;
        repeat (4) @(negedge clk);
        sp = set_pulses;
        t = time_now;
        pps_in = 1'b1;
        repeat (8) @(negedge clk);
        chk(time_now == t + 64'd8, "R4 unarmed count", time_now, t + 64'd8);
        chk(set_pulses == sp, "R4 no time_set", 64'(set_pulses), 64'(sp));

        // R5 arming while the pulse is held high
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd1);
        t = time_now;
        repeat (8) @(negedge clk);
        chk(armed == 1'b1, "R5 still armed", 64'(armed), 64'd1);
        chk(time_now == t + 64'd8, "R5 no load on level", time_now, t + 64'd8);
        pps_in = 1'b0;
        repeat (4) @(negedge clk);
        pps_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(time_now == 64'd0, "R5 load on new edge", time_now, 64'd0);
        pps_in = 1'b0;

        // R6 on-time firing
        wr(3'd7, 32'd3);
        push_op(time_now + 64'd60, 2'd0, 32'h0000_00A1);
        drain();
        chk(late_flag == 1'b0, "R8 on-time keeps flag low", 64'(late_flag), 64'd0);

        // R8 overdue firing and clear
        push_op(64'd5, 2'd2, 32'h0000_00B2);
        drain();
        chk(late_flag == 1'b1, "R8 sticky late", 64'(late_flag), 64'd1);
        repeat (5) @(negedge clk);
        chk(late_flag == 1'b1, "R8 late holds", 64'(late_flag), 64'd1);
        wr(3'd7, 32'd1);
        chk(late_flag == 1'b0, "R8 late cleared", 64'(late_flag), 64'd0);

        // R7 order of issue, only the head is compared
        t = time_now;
        push_op(t + 64'd80, 2'd1, 32'h0000_00C3);
        push_op(t + 64'd40, 2'd2, 32'h0000_00C4);
        drain();
        wr(3'd7, 32'd1);

        // R9 overflow on a full queue
        t = time_now;
        push_op(t + 64'd200, 2'd0, 32'h0000_0D01);
        push_op(t + 64'd201, 2'd1, 32'h0000_0D02);
        push_op(t + 64'd202, 2'd2, 32'h0000_0D03);
        push_op(t + 64'd203, 2'd3, 32'h0000_0D04);
        chk(ovf_flag == 1'b0, "R9 no overflow yet", 64'(ovf_flag), 64'd0);
        wr(3'd5, 32'h0000_DEAD);
        wr(3'd6, 32'd1);
        chk(ovf_flag == 1'b1, "R9 overflow set", 64'(ovf_flag), 64'd1);
        drain();
        repeat (30) @(negedge clk);
        chk(ovf_flag == 1'b1, "R9 overflow sticky", 64'(ovf_flag), 64'd1);
        wr(3'd7, 32'd2);
        chk(ovf_flag == 1'b0, "R9 overflow cleared", 64'(ovf_flag), 64'd0);
        chk(late_flag == 1'b0, "R8 on-time batch not late", 64'(late_flag), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule